// File: doc/BRIEF.md
# Frequency-locked loop lock monitor

This block watches a digitally controlled oscillator and decides whether the frequency-locked loop that steers it has reached its target. It runs on the oscillator clock. The reference side supplies one level that toggles once per comparison cycle, and the block brings that level into the oscillator domain. Each toggle closes one comparison cycle. The oscillator cycles counted since the previous toggle, minus a programmed multiplier target, give a signed count error.

The count error drives four things:

- A lock qualifier. Lock is declared only after a run of consecutive samples inside a tight window. Once declared, lock is held while samples stay inside a wider window.
- A sticky loss-of-lock flag. Software clears it with a read-then-write-one handshake.
- A loop-filter feed. Before lock it passes every error straight through. While locked it gives one averaged update for every four samples.
- An output-divider select. It asks for an extra halving of the output clock until the loop has locked once in the current run.

A power-down input stops sampling and drops lock. It does not count as an unexpected loss.

Top module: `fll_lock_monitor`

## Requirements
- R1: For every comparison cycle, `cycle_done` pulses for one clock and `count_err` equals the number of oscillator clocks between two successive cycle boundaries minus `mult_target`, as a two's-complement value. The first boundary after reset, or after `fll_off` falls, only starts counting and produces no pulse.
- R2: While unlocked, `locked` rises one clock after the sample that completes QUAL_CNT consecutive errors inside [LOCK_LO, LOCK_HI]. A default of 3 samples inside [-2, 2] is used. Any sample outside that window restarts the run.
- R3: While locked, a sample inside [UNLOCK_LO, UNLOCK_HI] keeps `locked` high. The default window is [-6, 6]. A sample outside it drops `locked` one clock later.
- R4: A drop of lock caused by a sample outside the unlock window sets `lol_flag`. The flag stays set until it is acknowledged or the block is reset.
- R5: A `flag_wr1` pulse clears `lol_flag` only if an earlier `stat_rd` pulse saw the flag set, and it uses up that read. A `flag_wr1` without a prior read leaves the flag set. If a new loss and the write land on the same clock, the loss wins.
- R6: While `fll_off` is high, `locked` goes low, no samples are taken, and `lol_flag` keeps its value.
- R7: While locked, `filt_upd` pulses once per four in-window samples. `filt_err` then carries the sum of those four errors shifted right arithmetically by 2, which rounds toward minus infinity.
- R8: A sample taken while unlocked, and the sample that causes loss of lock, each produce `filt_upd` on the next clock with `filt_err` equal to that sample's error. Such a sample also clears any partial average.
- R9: `div2_sel` is high from reset, and again from `fll_off`, until the first lock. After that it stays low, even when lock is later lost, until the next reset or `fll_off`.
- R10: After reset, `locked`, `lol_flag`, `cycle_done` and `filt_upd` are low and `div2_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco_clk | input | 1 | Oscillator clock; all state runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tgl | input | 1 | Reference-domain level, toggled once per comparison cycle |
| fll_off | input | 1 | Power-down: stop sampling and drop lock |
| mult_target | input | CNT_W | Expected oscillator clocks per comparison cycle |
| stat_rd | input | 1 | Status-read strobe (first step of the flag clear) |
| flag_wr1 | input | 1 | Write-one strobe (second step of the flag clear) |
| cycle_done | output | 1 | One-clock pulse: a new count error is valid |
| count_err | output | CNT_W+1 | Signed count error of the last comparison cycle |
| locked | output | 1 | Lock indication |
| lol_flag | output | 1 | Sticky loss-of-lock status |
| div2_sel | output | 1 | High: select the extra divide-by-two on the output |
| filt_upd | output | 1 | One-clock loop-filter update strobe |
| filt_err | output | CNT_W+1 | Signed error or four-sample average for the filter |

## Verification
The acknowledge write and a loss-of-lock sample can land on the same clock. The bench provokes this on purpose. After arming the clear with a status read and relocking, it drives `flag_wr1` in exactly the cycle where `cycle_done` presents an error outside the unlock window. It then expects `lol_flag` to stay set, `locked` to drop and the read to be used up, so a later write without a new read still leaves the flag set. A second overlap comes from the averaging path: a loss sample can arrive part-way through a group of four. The bench then expects a plain pass-through update, not an average.

// File: rtl/fll_lock_pkg.sv
package fll_lock_pkg;

   typedef enum logic {
      LK_HUNT = 1'b0,
      LK_HELD = 1'b1
   } lock_state_e;

   function automatic logic win_hit(input int val, input int lo, input int hi);
      return (val >= lo) && (val <= hi);
   endfunction

endpackage

// File: rtl/fll_cycle_sync.sv
module fll_cycle_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tgl_i,
   output logic bnd_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fll_cycle_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              dly_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= ref_tgl_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= 1'b0;
      else        dly_q <= chain_q[STAGES-1];
   end

   assign bnd_o = chain_q[STAGES-1] ^ dly_q;

endmodule

// File: rtl/fll_pulse_counter.sv
module fll_pulse_counter #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1,
   localparam int EW      = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off_i,
   input  logic             bnd_i,
   input  logic [CNT_W-1:0] target_i,
   output logic [EW-1:0]    err_o,
   output logic             vld_o
);

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("fll_pulse_counter: CNT_W must be at least 3");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             primed_q;
   logic [EW-1:0]    diff;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   assign diff = {1'b0, cnt_q} - {1'b0, target_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         primed_q <= 1'b0;
         err_o    <= '0;
         vld_o    <= 1'b0;
      end else if (off_i) begin
         cnt_q    <= '0;
         primed_q <= 1'b0;
         vld_o    <= 1'b0;
      end else if (bnd_i) begin
         cnt_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
         primed_q <= 1'b1;
         vld_o    <= primed_q;
         if (primed_q) err_o <= diff;
      end else begin
         cnt_q <= cnt_inc;
         vld_o <= 1'b0;
      end
   end

   AST_SAMPLE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> $past(bnd_i)) else $error("sample without boundary"); // R1
   AST_NO_SAMPLE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> !$past(off_i)) else $error("sample during power-down"); // R6

endmodule

// File: rtl/fll_lock_fsm.sv
module fll_lock_fsm
   import fll_lock_pkg::*;
#(
   parameter int EW        = 9,
   parameter int LOCK_LO   = -2,
   parameter int LOCK_HI   = 2,
   parameter int UNLOCK_LO = -6,
   parameter int UNLOCK_HI = 6,
   parameter int QUAL_CNT  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          off_i,
   input  logic [EW-1:0] err_i,
   input  logic          vld_i,
   input  logic          stat_rd_i,
   input  logic          flag_wr1_i,
   output logic          locked_o,
   output logic          lol_o,
   output logic          div2_o,
   output logic          acc_en_o,
   output logic          pass_en_o
);

   localparam logic [2:0] QUAL_LAST = 3'(QUAL_CNT - 1);

   generate
      if (QUAL_CNT < 1 || QUAL_CNT > 7) begin : g_bad_qual
         $error("fll_lock_fsm: QUAL_CNT must be 1..7");
      end
      if (UNLOCK_LO > LOCK_LO || UNLOCK_HI < LOCK_HI || LOCK_LO > LOCK_HI) begin : g_bad_win
         $error("fll_lock_fsm: unlock window must enclose lock window");
      end
   endgenerate

   lock_state_e state_q;
   logic [2:0]  qual_q;
   logic        ever_q;
   logic        arm_q;
   logic        lol_q;
   int          err_int;
   logic        in_lock;
   logic        in_unlock;
   logic        live;
   logic        loss_now;
   logic        clr_now;

   assign err_int   = int'($signed(err_i));
   assign in_lock   = win_hit(err_int, LOCK_LO, LOCK_HI);
   assign in_unlock = win_hit(err_int, UNLOCK_LO, UNLOCK_HI);
   assign live      = vld_i && !off_i;
   assign loss_now  = live && (state_q == LK_HELD) && !in_unlock;
   assign clr_now   = flag_wr1_i && arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LK_HUNT;
         qual_q  <= '0;
         ever_q  <= 1'b0;
      end else if (off_i) begin
         state_q <= LK_HUNT;
         qual_q  <= '0;
         ever_q  <= 1'b0;
      end else if (vld_i) begin
         case (state_q)
            LK_HUNT: begin
               if (!in_lock) begin
                  qual_q <= '0;
               end else if (qual_q == QUAL_LAST) begin
                  qual_q  <= '0;
                  state_q <= LK_HELD;
                  ever_q  <= 1'b1;
               end else begin
                  qual_q <= qual_q + 3'd1;
               end
            end
            LK_HELD: begin
               if (!in_unlock) begin
                  state_q <= LK_HUNT;
                  qual_q  <= '0;
               end
            end
            default: state_q <= LK_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lol_q <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (loss_now)     lol_q <= 1'b1;
         else if (clr_now) lol_q <= 1'b0;
         if (flag_wr1_i)                arm_q <= stat_rd_i && lol_q;
         else if (stat_rd_i && lol_q)   arm_q <= 1'b1;
      end
   end

   assign locked_o  = (state_q == LK_HELD);
   assign lol_o     = lol_q;
   assign div2_o    = !ever_q;
   assign acc_en_o  = live && (state_q == LK_HELD) && in_unlock;
   assign pass_en_o = live && !((state_q == LK_HELD) && in_unlock);

   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(vld_i && in_lock)) else $error("lock without in-window sample"); // R2
   AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_o) |-> $past(off_i || (vld_i && !in_unlock))) else $error("lock dropped without cause"); // R3
   AST_LOSS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && vld_i && !off_i && !in_unlock) |=> lol_o) else $error("loss not flagged"); // R4
   AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lol_o) |-> $past(flag_wr1_i)) else $error("flag cleared without write"); // R5
   AST_OFF_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (off_i && !flag_wr1_i) |=> lol_o == $past(lol_o)) else $error("power-down touched flag"); // R6
   AST_DIV_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> !div2_o) else $error("divide-by-two while locked"); // R9

endmodule

// File: rtl/fll_err_avg.sv
module fll_err_avg #(
   parameter int EW       = 9,
   parameter int AVG_LOG2 = 2,
   localparam int SW      = EW + AVG_LOG2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          off_i,
   input  logic [EW-1:0] err_i,
   input  logic          acc_en_i,
   input  logic          pass_en_i,
   output logic          upd_vld_o,
   output logic [EW-1:0] upd_val_o
);

   generate
      if (AVG_LOG2 < 1 || AVG_LOG2 > 4) begin : g_bad_avg
         $error("fll_err_avg: AVG_LOG2 must be 1..4");
      end
   endgenerate

   logic signed [SW-1:0]  sum_q;
   logic signed [SW-1:0]  sum_nxt;
   logic [AVG_LOG2-1:0]   grp_q;
   logic signed [EW-1:0]  err_s;

   assign err_s   = $signed(err_i);
   assign sum_nxt = sum_q + SW'(err_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q     <= '0;
         grp_q     <= '0;
         upd_vld_o <= 1'b0;
         upd_val_o <= '0;
      end else if (off_i) begin
         sum_q     <= '0;
         grp_q     <= '0;
         upd_vld_o <= 1'b0;
      end else if (pass_en_i) begin
         sum_q     <= '0;
         grp_q     <= '0;
         upd_vld_o <= 1'b1;
         upd_val_o <= err_i;
      end else if (acc_en_i) begin
         if (&grp_q) begin
            sum_q     <= '0;
            grp_q     <= '0;
            upd_vld_o <= 1'b1;
            upd_val_o <= EW'(sum_nxt >>> AVG_LOG2);
         end else begin
            sum_q     <= sum_nxt;
            grp_q     <= grp_q + 1'b1;
            upd_vld_o <= 1'b0;
         end
      end else begin
         upd_vld_o <= 1'b0;
      end
   end

   AST_UPD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld_o |-> $past(acc_en_i || pass_en_i)) else $error("update without sample"); // R7
   AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en_i && pass_en_i)) else $error("pass and average together"); // R8

endmodule

// File: rtl/fll_lock_monitor.sv
module fll_lock_monitor #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_LO     = -2,
   parameter int LOCK_HI     = 2,
   parameter int UNLOCK_LO   = -6,
   parameter int UNLOCK_HI   = 6,
   parameter int QUAL_CNT    = 3,
   parameter int AVG_LOG2    = 2,
   localparam int EW         = CNT_W + 1
) (
   input  logic             dco_clk,
   input  logic             rst_n,
   input  logic             ref_tgl,
   input  logic             fll_off,
   input  logic [CNT_W-1:0] mult_target,
   input  logic             stat_rd,
   input  logic             flag_wr1,
   output logic             cycle_done,
   output logic [EW-1:0]    count_err,
   output logic             locked,
   output logic             lol_flag,
   output logic             div2_sel,
   output logic             filt_upd,
   output logic [EW-1:0]    filt_err
);

   localparam int ERR_MAX = (1 << CNT_W) - 1;

   generate
      if (UNLOCK_HI > ERR_MAX || UNLOCK_LO < -ERR_MAX) begin : g_bad_range
         $error("fll_lock_monitor: unlock window exceeds error range");
      end
   endgenerate

   logic          bnd;
   logic [EW-1:0] err;
   logic          err_vld;
   logic          acc_en;
   logic          pass_en;

   fll_cycle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (dco_clk),
      .rst_n     (rst_n),
      .ref_tgl_i (ref_tgl),
      .bnd_o     (bnd)
   );

   fll_pulse_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_count (
      .clk      (dco_clk),
      .rst_n    (rst_n),
      .off_i    (fll_off),
      .bnd_i    (bnd),
      .target_i (mult_target),
      .err_o    (err),
      .vld_o    (err_vld)
   );

   fll_lock_fsm #(
      .EW(EW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI),
      .UNLOCK_LO(UNLOCK_LO), .UNLOCK_HI(UNLOCK_HI), .QUAL_CNT(QUAL_CNT)
   ) u_fsm (
      .clk        (dco_clk),
      .rst_n      (rst_n),
      .off_i      (fll_off),
      .err_i      (err),
      .vld_i      (err_vld),
      .stat_rd_i  (stat_rd),
      .flag_wr1_i (flag_wr1),
      .locked_o   (locked),
      .lol_o      (lol_flag),
      .div2_o     (div2_sel),
      .acc_en_o   (acc_en),
      .pass_en_o  (pass_en)
   );

   fll_err_avg #(.EW(EW), .AVG_LOG2(AVG_LOG2)) u_avg (
      .clk       (dco_clk),
      .rst_n     (rst_n),
      .off_i     (fll_off),
      .err_i     (err),
      .acc_en_i  (acc_en),
      .pass_en_i (pass_en),
      .upd_vld_o (filt_upd),
      .upd_val_o (filt_err)
   );

   assign cycle_done = err_vld;
   assign count_err  = err;

endmodule

// File: tb/fll_lock_monitor_bench.sv
module fll_lock_monitor_bench;

   localparam int CNT_W  = 8;
   localparam int EW     = CNT_W + 1;
   localparam int TARGET = 20;
   localparam int L_LO = -2, L_HI = 2, U_LO = -6, U_HI = 6, QUAL = 3;

   logic             dco_clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ref_tgl = 1'b0;
   logic             fll_off = 1'b0;
   logic [CNT_W-1:0] mult_target = CNT_W'(TARGET);
   logic             stat_rd = 1'b0;
   logic             flag_wr1 = 1'b0;
   logic             cycle_done, locked, lol_flag, div2_sel, filt_upd;
   logic [EW-1:0]    count_err, filt_err;

   fll_lock_monitor #(.CNT_W(CNT_W), .LOCK_LO(L_LO), .LOCK_HI(L_HI),
      .UNLOCK_LO(U_LO), .UNLOCK_HI(U_HI), .QUAL_CNT(QUAL)) u_fll_lock_monitor (
      .dco_clk(dco_clk), .rst_n(rst_n), .ref_tgl(ref_tgl), .fll_off(fll_off),
      .mult_target(mult_target), .stat_rd(stat_rd), .flag_wr1(flag_wr1),
      .cycle_done(cycle_done), .count_err(count_err), .locked(locked),
      .lol_flag(lol_flag), .div2_sel(div2_sel), .filt_upd(filt_upd), .filt_err(filt_err));

   always #2.5 dco_clk = ~dco_clk;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // model state: expected outputs after the next edge
   bit m_locked = 0, m_lol = 0, m_div2 = 1, m_fv = 0, m_arm = 0;
   int m_fval = 0, m_q = 0, m_sum = 0, m_grp = 0;
   bit b_primed = 0, pend_ok = 0;
   int pend_e = 0, since_tgl = 0;
   bit rd_req = 0, wr_req = 0, off_req = 0, tgl_req = 0, collide = 0;

   function automatic bit in_lock(int e);   return e >= L_LO && e <= L_HI; endfunction
   function automatic bit in_unlock(int e); return e >= U_LO && e <= U_HI; endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit model_sample(int e);
      bit loss = 0;
      if (!m_locked) begin
         m_fv = 1; m_fval = e; m_sum = 0; m_grp = 0;
         if (in_lock(e)) begin
            if (m_q == QUAL - 1) begin m_locked = 1; m_div2 = 0; m_q = 0; end
            else m_q++;
         end else m_q = 0;
      end else if (in_unlock(e)) begin
         m_sum += e; m_grp++;
         if (m_grp == 4) begin m_fv = 1; m_fval = m_sum >>> 2; m_sum = 0; m_grp = 0; end
      end else begin
         m_locked = 0; loss = 1; m_fv = 1; m_fval = e; m_sum = 0; m_grp = 0; m_q = 0;
      end
      return loss;
   endfunction

   task automatic step();
      bit loss = 0;
      bit lol_cur, arm_cur;
      since_tgl++;
      check(locked === m_locked, "R2/R3 locked", int'(locked), int'(m_locked));
      check(lol_flag === m_lol, "R4/R5 lol_flag", int'(lol_flag), int'(m_lol));
      check(div2_sel === m_div2, "R9 div2_sel", int'(div2_sel), int'(m_div2));
      check(filt_upd === m_fv, "R7/R8 filt_upd", int'(filt_upd), int'(m_fv));
      if (m_fv && filt_upd)
         check(int'($signed(filt_err)) == m_fval, "R7/R8 filt_err", int'($signed(filt_err)), m_fval);
      m_fv = 0;
      if (cycle_done === 1'b1) begin
         check(pend_ok, "R1 unexpected cycle_done", 1, 0);
         if (pend_ok) begin
            check(int'($signed(count_err)) == pend_e, "R1 count_err", int'($signed(count_err)), pend_e);
            loss = model_sample(pend_e);
            if (collide) begin wr_req = 1; collide = 0; end
         end
         pend_ok = 0;
      end
      lol_cur = m_lol; arm_cur = m_arm;
      stat_rd  = rd_req;
      flag_wr1 = wr_req;
      if (loss) m_lol = 1;
      else if (wr_req && arm_cur) m_lol = 0;
      if (wr_req) m_arm = rd_req && lol_cur;
      else if (rd_req && lol_cur) m_arm = 1;
      fll_off = off_req;
      if (off_req) begin
         m_locked = 0; m_div2 = 1; m_q = 0; m_sum = 0; m_grp = 0; m_fv = 0;
         b_primed = 0; pend_ok = 0;
      end
      if (tgl_req) begin
         ref_tgl = ~ref_tgl;
         if (b_primed) begin pend_e = since_tgl - TARGET; pend_ok = 1; end
         b_primed = 1;
         since_tgl = 0;
      end
      rd_req = 0; wr_req = 0; tgl_req = 0;
   endtask

   task automatic gap(int n, bit tog);
      for (int i = 0; i < n; i++) begin
         @(negedge dco_clk);
         tgl_req = tog && (i == n - 1);
         step();
      end
   endtask

   task automatic sample(int e);
      gap(TARGET + e, 1'b1);
   endtask

   task automatic power_down();
      gap(6, 1'b0);
      off_req = 1; gap(3, 1'b0); off_req = 0;
      gap(1, 1'b0);
      sample(0);            // re-prime
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge dco_clk);
      // R10: reset state
      check(locked === 1'b0 && lol_flag === 1'b0, "R10 locked/lol at reset", int'(locked), 0);
      check(div2_sel === 1'b1, "R10 div2_sel at reset", int'(div2_sel), 1);
      check(cycle_done === 1'b0 && filt_upd === 1'b0, "R10 strobes at reset", int'(cycle_done), 0);
      rst_n = 1'b1;
      sample(0);                                   // R1 prime only
      // R2: run broken by an out-of-lock sample
      sample(1); sample(-2); sample(4); sample(0); sample(2);
      sample(-1);                                  // third in a row: lock
      // R7: averaging with floor rounding (-5-4+2+1 = -6 -> -2)
      sample(-5); sample(-4); sample(2); sample(1);
      sample(6); sample(-6); sample(3);
      // R3/R4/R8: loss mid-group passes the error through
      sample(7);
      // R5: write without read keeps the flag
      wr_req = 1; gap(1, 1'b0);
      rd_req = 1; gap(1, 1'b0);
      wr_req = 1; gap(1, 1'b0);                    // now it clears
      // R5 collision: arm, relock, then lose lock on the write cycle
      sample(-9);
      sample(0); sample(0); sample(1);
      sample(-8);                                  // loss, lol set
      rd_req = 1; gap(1, 1'b0);
      sample(0); sample(0); sample(0);             // relock, R9 stays low after loss
      collide = 1; sample(10);                     // loss and write together: loss wins
      wr_req = 1; gap(1, 1'b0);                    // read used up: stays set
      // R6: power-down while locked keeps lol_flag
      sample(0); sample(0); sample(0);
      power_down();
      sample(1); sample(1); sample(1);
      rd_req = 1; gap(1, 1'b0);
      wr_req = 1; gap(1, 1'b0);
      // random phase
      for (int k = 0; k < 400; k++) begin
         int r = int'($urandom_range(0, 99));
         int e;
         if (r < 55)      e = int'($urandom_range(0, 4)) - 2;
         else if (r < 85) e = int'($urandom_range(0, 12)) - 6;
         else             e = int'($urandom_range(0, 16)) - 8;
         if (r == 0) power_down();
         if (r == 1 || r == 2) begin rd_req = 1; gap(1, 1'b0); end
         if (r == 3 || r == 4) begin wr_req = 1; gap(1, 1'b0); end
         if (r == 5) collide = 1;
         sample(e);
      end
      gap(10, 1'b0);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule